// File: doc/BRIEF.md
# Framebuffer Display Scan Controller

This block scans a fixed 640x480 true-colour picture out of memory. A beam-position counter pair walks the standard 640x480 frame timing (800 clocks per line, 525 lines per frame) and produces active-low horizontal and vertical sync. During the visible area it issues one memory read per pixel, with a request/valid handshake. Each returned 32-bit word is unpacked into 8-bit red, green and blue outputs.

Software programs two registers: a framebuffer base, of which only the 11 upper address bits are kept, and a control word with a display-enable bit and a 180-degree rotation bit. Rows are laid out with a pitch of 1024 words. Only the first 640 words of a row are fetched, so the remaining words of each row are never read. Rotation reverses both scan directions. Base and rotation take effect at the start of vertical blanking, so a frame never mixes two settings. The enable bit acts at once.

Top module: `fb_scan_ctrl`

## Requirements
- R1: Horizontal total is H_VIS+H_FP+H_SYNC+H_BP clocks and vertical total is V_VIS+V_FP+V_SYNC+V_BP lines (defaults 640/16/96/48 and 480/10/2/33). Counting x and y from 0 at the first visible pixel, hsync_no is low exactly for x in [H_VIS+H_FP, H_VIS+H_FP+H_SYNC) and vsync_no is low exactly for lines y in [V_VIS+V_FP, V_VIS+V_FP+V_SYNC).
- R2: mem_req_o is high exactly in the cycles where x < H_VIS and y < V_VIS while the display is enabled, giving one request per visible pixel.
- R3: With rotation off, mem_addr_o for pixel (x, y) is base + (y*2^STRIDE_LOG2 + x)*4, with a default pitch of 1024 words.
- R4: With rotation on, mem_addr_o for pixel (x, y) is base + ((V_VIS-1-y)*2^STRIDE_LOG2 + (H_VIS-1-x))*4.
- R5: A base write keeps only bits 31:21 (BASE_LSB=21). Reading the base returns those bits with bits 20:0 as zero.
- R6: Register index 0 is the base and index 1 is control (bit 0 enable, bit 1 rotate). With BYTE_ADDR=1 the index is reg_addr_i>>2, so control sits at byte offset 4. With BYTE_ADDR=0 the index is reg_addr_i, so control sits at address 1. Control reads back its two bits with the other bits zero.
- R7: One cycle after mem_valid_i is sampled high, red_o/green_o/blue_o show bits 23:16/15:8/7:0 of mem_rdata_i; bits 31:24 are ignored. When mem_valid_i is low, the colour outputs are zero on the next cycle.
- R8: Writing 0 to control stops requests from the next cycle and zeroes the colour outputs. Sync generation continues.
- R9: New base and rotate values are applied at the first cycle of vertical blanking (x=0, y=V_VIS). Until then the frame in progress keeps the old values.
- R10: During and right after reset both registers read zero, mem_req_o is low, the colour outputs are zero and both syncs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register address (byte or word, per BYTE_ADDR) |
| reg_wdata_i | input | AW | Register write data |
| reg_rdata_o | output | AW | Read data for reg_addr_i (combinational) |
| mem_req_o | output | 1 | Pixel read request |
| mem_addr_o | output | AW | Byte address of the requested pixel word |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |
| red_o | output | 8 | Red level |
| green_o | output | 8 | Green level |
| blue_o | output | 8 | Blue level |

## Verification
Sync, request and address are combinational from the beam counters, so they are due in the same cycle as the beam position. That position is the number of clock edges since reset, modulo the frame length. A colour value is due two edges after its request: one edge for the memory model to return valid, one for the output register. The enable bit acts one edge after its write. Base and rotate act at the first blanking cycle. The bench samples every output at the falling edge. It keeps two-deep histories of its own expected request, address and enable, so each colour check compares against the request made two cycles earlier. It runs a reduced frame geometry so that many frames fit in the run, and it writes registers only in the visible area, away from the latch edge.

// File: rtl/fb_scan_pkg.sv
`timescale 1ns/1ps
package fb_scan_pkg;
  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  function automatic rgb_t unpack_word(input logic [31:0] w);
    rgb_t c;
    c.r = w[23:16];
    c.g = w[15:8];
    c.b = w[7:0];
    return c;
  endfunction
endpackage

// File: rtl/fb_scan_timing.sv
`timescale 1ns/1ps
module fb_scan_timing #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW    = $clog2(H_TOT),
  localparam int VW    = $clog2(V_TOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] x_o,
  output logic [VW-1:0] y_o,
  output logic          visible_o,
  output logic          vblank_start_o,
  output logic          hsync_no,
  output logic          vsync_no
);
  localparam logic [HW-1:0] HLast  = HW'(H_TOT - 1);
  localparam logic [HW-1:0] HVis   = HW'(H_VIS);
  localparam logic [HW-1:0] HSyncB = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HSyncE = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] VLast  = VW'(V_TOT - 1);
  localparam logic [VW-1:0] VVis   = VW'(V_VIS);
  localparam logic [VW-1:0] VVisL  = VW'(V_VIS - 1);
  localparam logic [VW-1:0] VSyncB = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VSyncE = VW'(V_VIS + V_FP + V_SYNC);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          h_end;

  assign h_end = (h_q == HLast);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_end) begin
      h_q <= '0;
      v_q <= (v_q == VLast) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign x_o            = h_q;
  assign y_o            = v_q;
  assign visible_o      = (h_q < HVis) && (v_q < VVis);
  assign vblank_start_o = h_end && (v_q == VVisL);
  assign hsync_no       = !((h_q >= HSyncB) && (h_q < HSyncE));
  assign vsync_no       = !((v_q >= VSyncB) && (v_q < VSyncE));
endmodule

// File: rtl/fb_reg_file.sv
`timescale 1ns/1ps
module fb_reg_file #(
  parameter int AW        = 32,
  parameter int BASE_LSB  = 21,
  parameter int REG_AW    = 3,
  parameter bit BYTE_ADDR = 1'b1,
  localparam int BASE_W   = AW - BASE_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [AW-1:0]     wdata_i,
  output logic [AW-1:0]     rdata_o,
  input  logic              latch_i,
  output logic              en_o,
  output logic              rot_o,
  output logic [BASE_W-1:0] base_o
);
  logic [REG_AW-1:0] idx;
  logic              sel_base, sel_ctrl;
  logic [BASE_W-1:0] base_sh, base_act;
  logic              rot_sh, rot_act, en_q;
  logic              unused_wdata;

  if (BYTE_ADDR) begin : g_byte_idx
    assign idx = addr_i >> 2;
  end else begin : g_word_idx
    assign idx = addr_i;
  end

  assign sel_base     = (idx == '0);
  assign sel_ctrl     = (idx == REG_AW'(1));
  assign unused_wdata = ^wdata_i[BASE_LSB-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_sh  <= '0;
      rot_sh   <= 1'b0;
      en_q     <= 1'b0;
      base_act <= '0;
      rot_act  <= 1'b0;
    end else begin
      if (we_i && sel_base) base_sh <= wdata_i[AW-1:BASE_LSB];
      if (we_i && sel_ctrl) begin
        en_q   <= wdata_i[0];
        rot_sh <= wdata_i[1];
      end
      // frame-consistent copy, taken as blanking begins
      if (latch_i) begin
        base_act <= base_sh;
        rot_act  <= rot_sh;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_base)      rdata_o = {base_sh, {BASE_LSB{1'b0}}};
    else if (sel_ctrl) rdata_o = {{(AW-2){1'b0}}, rot_sh, en_q};
  end

  assign en_o   = en_q;
  assign rot_o  = rot_act;
  assign base_o = base_act;
endmodule

// File: rtl/fb_addr_gen.sv
`timescale 1ns/1ps
module fb_addr_gen #(
  parameter int AW          = 32,
  parameter int BASE_LSB    = 21,
  parameter int STRIDE_LOG2 = 10,
  parameter int H_VIS       = 640,
  parameter int V_VIS       = 480,
  parameter int HW          = 10,
  parameter int VW          = 10,
  localparam int BASE_W     = AW - BASE_LSB
) (
  input  logic [HW-1:0]     x_i,
  input  logic [VW-1:0]     y_i,
  input  logic              rot_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [AW-1:0]     addr_o
);
  localparam logic [HW-1:0] XMax = HW'(H_VIS - 1);
  localparam logic [VW-1:0] YMax = VW'(V_VIS - 1);

  logic [HW-1:0] xe;
  logic [VW-1:0] ye;
  logic [AW-1:0] word_off;

  assign xe       = rot_i ? (XMax - x_i) : x_i;
  assign ye       = rot_i ? (YMax - y_i) : y_i;
  assign word_off = (AW'(ye) << STRIDE_LOG2) + AW'(xe);
  assign addr_o   = {base_i, {BASE_LSB{1'b0}}} + (word_off << 2);
endmodule

// File: rtl/fb_pixel_unpack.sv
`timescale 1ns/1ps
module fb_pixel_unpack
  import fb_scan_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        en_i,
  input  logic [31:0] word_i,
  output rgb_t        rgb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rgb_o <= '0;
    else if (valid_i && en_i) rgb_o <= unpack_word(word_i);
    else                     rgb_o <= '0;
  end
endmodule

// File: rtl/fb_scan_ctrl.sv
`timescale 1ns/1ps
module fb_scan_ctrl
  import fb_scan_pkg::*;
#(
  parameter int AW          = 32,
  parameter int BASE_LSB    = 21,
  parameter int REG_AW      = 3,
  parameter bit BYTE_ADDR   = 1'b1,
  parameter int STRIDE_LOG2 = 10,
  parameter int H_VIS       = 640,
  parameter int H_FP        = 16,
  parameter int H_SYNC      = 96,
  parameter int H_BP        = 48,
  parameter int V_VIS       = 480,
  parameter int V_FP        = 10,
  parameter int V_SYNC      = 2,
  parameter int V_BP        = 33
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [AW-1:0]     reg_wdata_i,
  output logic [AW-1:0]     reg_rdata_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              hsync_no,
  output logic              vsync_no,
  output logic [7:0]        red_o,
  output logic [7:0]        green_o,
  output logic [7:0]        blue_o
);
  localparam int HTot   = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int VTot   = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW     = $clog2(HTot);
  localparam int VW     = $clog2(VTot);
  localparam int BASE_W = AW - BASE_LSB;

  logic [HW-1:0]     x;
  logic [VW-1:0]     y;
  logic              visible, vblank_start;
  logic              ctrl_en, rot_act;
  logic [BASE_W-1:0] base_act;
  rgb_t              rgb;

  fb_scan_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) timing_i (
    .clk_i, .rst_ni,
    .x_o(x), .y_o(y),
    .visible_o(visible), .vblank_start_o(vblank_start),
    .hsync_no, .vsync_no
  );

  fb_reg_file #(
    .AW(AW), .BASE_LSB(BASE_LSB), .REG_AW(REG_AW), .BYTE_ADDR(BYTE_ADDR)
  ) regs_i (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .latch_i(vblank_start),
    .en_o(ctrl_en), .rot_o(rot_act), .base_o(base_act)
  );

  fb_addr_gen #(
    .AW(AW), .BASE_LSB(BASE_LSB), .STRIDE_LOG2(STRIDE_LOG2),
    .H_VIS(H_VIS), .V_VIS(V_VIS), .HW(HW), .VW(VW)
  ) addr_i (
    .x_i(x), .y_i(y), .rot_i(rot_act), .base_i(base_act), .addr_o(mem_addr_o)
  );

  fb_pixel_unpack unpack_i (
    .clk_i, .rst_ni,
    .valid_i(mem_valid_i), .en_i(ctrl_en), .word_i(mem_rdata_i), .rgb_o(rgb)
  );

  assign mem_req_o = ctrl_en && visible;
  assign red_o     = rgb.r;
  assign green_o   = rgb.g;
  assign blue_o    = rgb.b;
endmodule

// File: rtl/fb_scan_ctrl_chk.sv
`timescale 1ns/1ps
module fb_scan_ctrl_chk #(
  parameter int BASE_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_en_i,
  input logic              mem_req_i,
  input logic              mem_valid_i,
  input logic              hsync_ni,
  input logic              vsync_ni,
  input logic              vblank_start_i,
  input logic              rot_act_i,
  input logic [BASE_W-1:0] base_act_i,
  input logic [23:0]       rgb_i
);
  // R2
  req_in_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> (hsync_ni && vsync_ni));

  // R1
  sync_then_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_ni |=> !mem_req_i);

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vblank_start_i |=> ($stable(base_act_i) && $stable(rot_act_i)));

  // R7
  rgb_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_valid_i |=> (rgb_i == 24'h0));

  // R8
  off_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en_i |=> (rgb_i == 24'h0));
endmodule

bind fb_scan_ctrl fb_scan_ctrl_chk #(.BASE_W(BASE_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_en_i(ctrl_en), .mem_req_i(mem_req_o),
  .mem_valid_i(mem_valid_i), .hsync_ni(hsync_no), .vsync_ni(vsync_no),
  .vblank_start_i(vblank_start), .rot_act_i(rot_act), .base_act_i(base_act),
  .rgb_i({red_o, green_o, blue_o})
);

// File: tb/fb_scan_ctrl_tb_top.sv
`timescale 1ns/1ps
module fb_scan_ctrl_tb_top;
  localparam int HV = 8, HF = 2, HS = 3, HB = 3;
  localparam int VV = 4, VF = 1, VS = 2, VB = 1;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int FR = HT * VT;
  localparam int SL2 = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, we_w = 1'b0;
  logic [2:0]  addr = '0, addr_w = '0;
  logic [31:0] wdata = '0, rdata, rdata_w;
  logic        mem_req, mem_valid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        hs_n, vs_n;
  logic [7:0]  red, green, blue;
  logic        d_req, d_hs, d_vs;
  logic [31:0] d_addr;
  logic [7:0]  d_r, d_g, d_b;

  always #4 clk = ~clk;

  fb_scan_ctrl #(.STRIDE_LOG2(SL2), .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata),
    .hsync_no(hs_n), .vsync_no(vs_n), .red_o(red), .green_o(green), .blue_o(blue));

  fb_scan_ctrl #(.BYTE_ADDR(1'b0), .STRIDE_LOG2(SL2), .H_VIS(HV), .H_FP(HF), .H_SYNC(HS),
    .H_BP(HB), .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)) dut_w_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we_w), .reg_addr_i(addr_w),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_w), .mem_req_o(d_req),
    .mem_addr_o(d_addr), .mem_valid_i(1'b0), .mem_rdata_i(32'h0),
    .hsync_no(d_hs), .vsync_no(d_vs), .red_o(d_r), .green_o(d_g), .blue_o(d_b));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit run_chk = 0, done = 0;
  logic [31:0] sh_base = '0, act_base = '0;
  logic        sh_en = 0, sh_rot = 0, act_rot = 0;
  logic        req_h1 = 0, req_h2 = 0, en_h1 = 0;
  logic [31:0] addr_h1 = '0, addr_h2 = '0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hA5C3_1E77;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    mem_valid <= mem_req;
    mem_rdata <= pat(mem_addr);
  end

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // per-cycle scoreboard
  always @(negedge clk) begin
    if (run_chk) begin
      int pos, x, y, xe, ye;
      logic ereq, ehs, evs;
      logic [31:0] eaddr, ergb;
      pos = cyc % FR; x = pos % HT; y = pos / HT;
      if (pos == VV * HT) begin act_base = sh_base; act_rot = sh_rot; end
      ereq  = sh_en && (x < HV) && (y < VV);
      ehs   = !(x >= HV + HF && x < HV + HF + HS);
      evs   = !(y >= VV + VF && y < VV + VF + VS);
      xe    = act_rot ? HV - 1 - x : x;
      ye    = act_rot ? VV - 1 - y : y;
      eaddr = act_base + 32'((ye * (1 << SL2) + xe) * 4);
      ergb  = (req_h2 && en_h1) ? {8'h0, pat(addr_h2)[23:0]} : 32'h0;
      check("R1", "hsync_no", {31'h0, hs_n}, {31'h0, ehs});
      check("R1", "vsync_no", {31'h0, vs_n}, {31'h0, evs});
      check("R2", "mem_req_o", {31'h0, mem_req}, {31'h0, ereq});
      if (ereq) check(act_rot ? "R4" : "R3", "mem_addr_o", mem_addr, eaddr);
      check(en_h1 ? "R7" : "R8", "rgb", {8'h0, red, green, blue}, ergb);
      req_h2 = req_h1; addr_h2 = addr_h1;
      req_h1 = ereq;   addr_h1 = eaddr; en_h1 = sh_en;
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
    if (a[2] == 1'b0) sh_base = d & 32'hFFE0_0000;
    else begin sh_en = d[0]; sh_rot = d[1]; end
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic regw_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we_w = 1'b1; addr_w = a; wdata = d;
    @(posedge clk); #1; we_w = 1'b0;
  endtask

  task automatic regw_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr_w = a; #1; d = rdata_w;
  endtask

  task automatic wait_pos(input int p);
    do @(negedge clk); while ((cyc % FR) != p);
  endtask

  initial begin
    logic [31:0] rd, r1, r2;
    void'($urandom(32'd20240611));
    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10", "rgb in reset", {8'h0, red, green, blue}, 32'h0);
    check("R10", "req in reset", {31'h0, mem_req}, 32'h0);
    check("R10", "syncs in reset", {30'h0, hs_n, vs_n}, 32'h3);
    addr = 3'd0; #1 check("R10", "base after reset", rdata, 32'h0);
    addr = 3'd4; #1 check("R10", "ctrl after reset", rdata, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); run_chk = 1;

    // R5 / R6 register map, byte addressed
    wait_pos(2);
    reg_wr(3'd0, 32'hFFFF_FFFF);
    reg_rd(3'd0, rd); check("R5", "base readback", rd, 32'hFFE0_0000);
    reg_wr(3'd4, 32'hFFFF_FFFE);
    reg_rd(3'd4, rd); check("R6", "ctrl readback at byte 4", rd, 32'h2);
    // R6 word addressed instance
    regw_wr(3'd1, 32'h3);
    regw_rd(3'd1, rd); check("R6", "word ctrl readback", rd, 32'h3);
    regw_wr(3'd0, 32'h1234_5678);
    regw_rd(3'd0, rd); check("R6", "word base readback", rd, 32'h1220_0000);
    regw_wr(3'd1, 32'h0);

    // R9 latch at vertical blanking
    wait_pos(2);
    reg_wr(3'd0, 32'h0060_0000);
    reg_wr(3'd4, 32'h1);
    wait_pos(0);
    wait_pos(10);
    reg_wr(3'd0, 32'h00A0_0000);
    wait_pos(20);
    check("R9", "old base held mid-frame", {21'h0, mem_addr[31:21]}, 32'h3);
    wait_pos(1);
    check("R9", "new base next frame", {21'h0, mem_addr[31:21]}, 32'h5);

    // R8 disable mid-frame, sync keeps running
    wait_pos(20);
    reg_wr(3'd4, 32'h0);
    wait_pos(30);
    check("R8", "no req when off", {31'h0, mem_req}, 32'h0);
    check("R8", "rgb zero when off", {8'h0, red, green, blue}, 32'h0);
    wait_pos(HT * 2 + HV + HF);
    check("R8", "hsync still active", {31'h0, hs_n}, 32'h0);

    // random frames
    for (int f = 0; f < 20; f++) begin
      wait_pos(2);
      r1 = $urandom;
      r2 = $urandom;
      reg_wr(3'd0, r1);
      reg_wr(3'd4, {30'h0, r2[2], (r2[1:0] != 2'b00)});
      if (r2[3]) begin
        wait_pos(30);
        reg_wr(3'd0, $urandom);
      end
    end
    wait_pos(FR - 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule